// File: doc/BRIEF.md
# Tick-Aligned Register Write Synchronizer

This block sits between a fast host bus and a real-time-clock core whose registers may change only on the one-second tick. A host write to one of the five synchronized registers (time, alarm, stopwatch, interrupt enable, prescaler) does not go straight to the register. It is parked in a single holding slot, together with its target address, and a pending flag is raised. At the next tick pulse the parked value is copied into its register. In that same cycle the pending flag drops and a sticky completion flag rises.

Only one write can be parked at a time. A synchronized write that arrives while another is parked is dropped without notice, and the parked value is kept. Software is expected to poll the pending flag before it writes. The status register is not synchronized. Its bits are write-one-to-clear and take effect on the next clock edge, whatever the tick does. The low status bits are sticky event flags set from a core-side input vector. Reads always return committed register contents, never the parked value.

Top module: `rtc_wsync`

## Requirements
- R1: A synchronized write (address 0 time, 1 alarm, 2 stopwatch, 3 interrupt enable, 4 prescaler) does not change what a read of that address returns until a tick commits it; reads return only committed values.
- R2: A synchronized write accepted while nothing is parked sets status bit 14 (pending) in the next cycle.
- R3: A tick in a cycle where a write is parked stores the parked data at the parked address. From the next cycle that address reads the new value, bit 14 reads 0 and bit 15 (complete) reads 1.
- R4: A synchronized write that arrives while a write is parked is discarded, and the parked address and data are kept unchanged.
- R5: If a write arrives in the same cycle as a tick while nothing is parked, the write is parked and is committed only by the following tick.
- R6: Writes to the status register (address 5) are write-one-to-clear and take effect in the next cycle with no tick wait. A 1 in bit 15 clears complete, and writes never change bit 14. A commit in the same cycle as a clear leaves bit 15 set.
- R7: Each bit of the event input sets the status bit at the same position (bits 0 to EVT_W-1), and the bit stays set until it is cleared. Writing 0xFFFF to status clears every sticky bit. An event arriving in the same cycle as its clear wins.
- R8: After reset, all five synchronized registers read 0 and status reads 0.
- R9: Writes to addresses 6 and 7 change nothing, and those addresses read 0.
- R10: A tick with nothing parked changes no register and no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle one-second enable pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | DATA_W | Host write data |
| evt_in | input | EVT_W | Core event pulses, one per low status bit |
| rd_addr | input | 3 | Host read address |
| rd_data | output | DATA_W | Read data: committed register or status word |

## Verification
The bench runs lone writes separated from the tick by several idle cycles. This separates a design that commits on the tick from one that commits at once or never. Back-to-back writes to different registers during a pending period show whether the second write is dropped or overwrites the slot. Writes landing in the same cycle as the tick, and clears landing in the same cycle as a commit or an event, fix the priority at the cycle boundary. Idle ticks and writes to unmapped addresses show that nothing moves when it should not. A behavioural model predicts every readable address and is compared on every clock.

// File: rtl/rtc_wsync_pkg.sv
package rtc_wsync_pkg;
    localparam int ADDR_W  = 3;
    localparam int N_SYNC  = 5;
    localparam int STAT_W  = 16;
    localparam int BIT_PND = 14;
    localparam int BIT_CMP = 15;

    typedef enum logic [ADDR_W-1:0] {
        A_TIME  = 3'd0,
        A_ALARM = 3'd1,
        A_SWCH  = 3'd2,
        A_IEN   = 3'd3,
        A_PRESC = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/rtc_wsync_hold.sv
module rtc_wsync_hold
    import rtc_wsync_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              pend,
    output logic              commit,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data
);
    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = st_q.pend & tick;
        if (commit) begin
            st_d.pend = 1'b0;
        end else if (req && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.addr = req_addr;
            st_d.data = req_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend      = st_q.pend;
    assign hold_addr = st_q.addr;
    assign hold_data = st_q.data;
endmodule

// File: rtl/rtc_wsync_bank.sv
module rtc_wsync_bank
    import rtc_wsync_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [ADDR_W-1:0]        c_addr,
    input  logic [DATA_W-1:0]        c_data,
    output logic [N_SYNC*DATA_W-1:0] regs_flat
);
    for (genvar g = 0; g < N_SYNC; g++) begin : g_reg
        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (commit && (c_addr == ADDR_W'(g))) val_d = c_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign regs_flat[g*DATA_W +: DATA_W] = val_q;
    end
endmodule

// File: rtl/rtc_wsync_stat.sv
module rtc_wsync_stat
    import rtc_wsync_pkg::*;
#(
    parameter int EVT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic [EVT_W-1:0]  evt,
    input  logic              commit,
    input  logic              pend,
    output logic [STAT_W-1:0] stat_word
);
    typedef struct packed {
        logic             cmp;
        logic [EVT_W-1:0] ev;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.cmp = st_q.cmp & ~clr_mask[BIT_CMP];
            st_d.ev  = st_q.ev & ~clr_mask[EVT_W-1:0];
        end
        if (commit) st_d.cmp = 1'b1;
        st_d.ev = st_d.ev | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_word              = '0;
        stat_word[EVT_W-1:0]   = st_q.ev;
        stat_word[BIT_PND]     = pend;
        stat_word[BIT_CMP]     = st_q.cmp;
    end
endmodule

// File: rtl/rtc_wsync.sv
module rtc_wsync
    import rtc_wsync_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic                     sync_req, stat_we, pend, commit;
    logic [ADDR_W-1:0]        hold_addr;
    logic [DATA_W-1:0]        hold_data;
    logic [N_SYNC*DATA_W-1:0] regs_flat;
    logic [STAT_W-1:0]        stat_word;

    assign sync_req = wr_en && (int'(wr_addr) < N_SYNC);
    assign stat_we  = wr_en && (wr_addr == A_STAT);

    rtc_wsync_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req(sync_req),
        .req_addr(wr_addr), .req_data(wr_data), .pend(pend),
        .commit(commit), .hold_addr(hold_addr), .hold_data(hold_data)
    );

    rtc_wsync_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(hold_addr),
        .c_data(hold_data), .regs_flat(regs_flat)
    );

    rtc_wsync_stat #(.EVT_W(EVT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr_we(stat_we),
        .clr_mask(wr_data[STAT_W-1:0]), .evt(evt_in), .commit(commit),
        .pend(pend), .stat_word(stat_word)
    );

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < N_SYNC)
            rd_data = regs_flat[int'(rd_addr)*DATA_W +: DATA_W];
        else if (rd_addr == A_STAT)
            rd_data = DATA_W'(stat_word);
    end
endmodule

// File: rtl/rtc_wsync_chk.sv
module rtc_wsync_chk
    import rtc_wsync_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic                     wr_en,
    input logic [2:0]               wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     pend,
    input logic [ADDR_W-1:0]        hold_addr,
    input logic [DATA_W-1:0]        hold_data,
    input logic [N_SYNC*DATA_W-1:0] regs_flat,
    input logic [STAT_W-1:0]        stat_word
);
    a_r1_no_move_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(regs_flat));

    a_r2_accept_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) < N_SYNC && !pend) |=> stat_word[BIT_PND]);

    a_r3_commit_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && tick) |=> (!stat_word[BIT_PND] && stat_word[BIT_CMP]));

    a_r4_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !tick) |=> ($stable(hold_addr) && $stable(hold_data) && pend));

    a_r6_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_STAT && wr_data[BIT_CMP] && !(pend && tick))
        |=> !stat_word[BIT_CMP]);

    a_r10_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pend) |=> $stable(regs_flat));
endmodule

bind rtc_wsync rtc_wsync_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend(pend), .hold_addr(hold_addr),
    .hold_data(hold_data), .regs_flat(regs_flat), .stat_word(stat_word)
);

// File: tb/rtc_wsync_tb.sv
`timescale 1ns/100ps
module rtc_wsync_tb;
    localparam int DW = 32;
    localparam int EW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [EW-1:0] evt_in = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // behavioural reference
    logic [DW-1:0] m_reg [5];
    bit            m_pend;
    int            m_haddr;
    logic [DW-1:0] m_hdata;
    bit            m_done;
    logic [EW-1:0] m_evt;

    rtc_wsync #(.DATA_W(DW), .EVT_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .evt_in(evt_in),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] expect_at(int a);
        if (a < 5) return m_reg[a];
        if (a == 5) return DW'({m_done, m_pend, 7'b0, m_evt});
        return '0;
    endfunction

    task automatic sweep(string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.4;
            checks++;
            if (rd_data !== expect_at(a)) begin
                errors++;
                $display("FAIL %s addr %0d got %h expected %h", tag, a, rd_data, expect_at(a));
            end
        end
    endtask

    task automatic model_edge(bit we, int a, logic [DW-1:0] d, bit tk, logic [EW-1:0] ev);
        bit was = m_pend;
        bit com = was && tk;
        if (com) begin
            m_reg[m_haddr] = m_hdata;
            m_pend = 0;
        end
        if (we && a == 5) begin
            if (d[15]) m_done = 0;
            m_evt = m_evt & ~d[EW-1:0];
        end
        if (we && a < 5 && !was) begin
            m_pend = 1; m_haddr = a; m_hdata = d;
        end
        if (com) m_done = 1;
        m_evt = m_evt | ev;
    endtask

    // one clock: drive after negedge, model at posedge, compare at next negedge
    task automatic cyc(string tag, bit we = 0, int a = 0, logic [DW-1:0] d = '0,
                       bit tk = 0, logic [EW-1:0] ev = '0);
        wr_en = we; wr_addr = 3'(a); wr_data = d; tick = tk; evt_in = ev;
        @(posedge clk);
        model_edge(we, a, d, tk, ev);
        @(negedge clk);
        wr_en = 0; tick = 0; evt_in = '0;
        sweep(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) m_reg[i] = '0;
        m_pend = 0; m_haddr = 0; m_hdata = '0; m_done = 0; m_evt = '0;
        repeat (3) @(negedge clk);
        sweep("R8");
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R8");

        // lone write, commit later (R2, R1, R3)
        cyc("R2", 1, 0, 32'hA5A5_0001);
        cyc("R1");
        cyc("R1");
        cyc("R3", 0, 0, '0, 1);
        cyc("R3");
        // clear complete (R6), bit 14 unaffected by writes
        cyc("R6", 1, 5, 32'h0000_4000);
        cyc("R6", 1, 5, 32'h0000_8000);
        // second write while pending dropped (R4)
        cyc("R2", 1, 1, 32'h1111_2222);
        cyc("R4", 1, 3, 32'h0000_00FF);
        cyc("R4", 1, 1, 32'hDEAD_BEEF);
        cyc("R3", 0, 0, '0, 1);
        cyc("R1", 1, 3, 32'h0000_0055);
        // write in tick cycle while pending: commit happens, write dropped (R4)
        cyc("R4", 1, 2, 32'h0000_0777, 1);
        // write with tick while idle: parked, committed next tick (R5)
        cyc("R5", 1, 2, 32'h0000_1234, 1);
        cyc("R5");
        cyc("R5", 0, 0, '0, 1);
        // idle ticks (R10)
        cyc("R10", 0, 0, '0, 1);
        cyc("R10", 0, 0, '0, 1);
        // commit and clear in same cycle: complete stays (R6)
        cyc("R6", 1, 4, 32'h0000_0003);
        cyc("R6", 1, 5, 32'h0000_8000, 1);
        // events (R7)
        cyc("R7", 0, 0, '0, 0, 7'h05);
        cyc("R7", 0, 0, '0, 0, 7'h40);
        cyc("R7", 1, 5, 32'h0000_0001, 0, 7'h01);
        cyc("R7", 1, 5, 32'h0000_FFFF);
        // unmapped writes (R9)
        cyc("R9", 1, 6, 32'hFFFF_FFFF);
        cyc("R9", 1, 7, 32'hFFFF_FFFF, 1);
        cyc("R9");
        // write committing to last register index, then back to back updates (R3)
        cyc("R3", 1, 4, 32'h0000_8001);
        cyc("R3", 0, 0, '0, 1);
        cyc("R1", 1, 0, 32'h0002_0000);
        cyc("R1", 0, 0, '0, 0, 7'h10);
        cyc("R3", 0, 0, '0, 1);
        cyc("R7", 1, 5, 32'h0000_FFFF);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule